// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the 32-bit register window of a shared-memory device that lets several processors signal one another. Software reaches four word registers inside a 256-byte window: an interrupt enable mask, an interrupt status word, a read-only own-position word and a write-only doorbell. A level interrupt output is raised when any status bit is also enabled in the mask. Reading the status word returns its value and clears it. A local event input can load an 8-bit value into the status word, for example when a notification from another processor arrives.

Software rings a doorbell by writing one word that holds a destination peer number and a vector number. The block checks both against a peer table that is supplied from outside: the highest live peer number and a vector count for each peer. A valid request produces a one-cycle notify pulse that carries the destination and the vector. A request that fails either check is discarded. The block does not decide how the notification travels onward.

Top module: `dbell_regblk`

## Requirements
- R1: After reset, the mask and status words read as zero and `irq` and `notify_valid` are low.
- R2: Word offset 0x00 is the mask. A write replaces all 32 bits, and a read returns the stored value.
- R3: Word offset 0x04 is the status. A bus write replaces all 32 bits. A read returns the current value and leaves the word at zero from the next cycle. A write in the same cycle takes priority over the clear.
- R4: `irq` is a register. It goes high one cycle after the stored status AND mask becomes nonzero, and low one cycle after that result becomes zero.
- R5: Word offset 0x08 reads as `own_id` zero-extended to 32 bits when `shm_mapped` is 1, and as 0xFFFFFFFF when `shm_mapped` is 0. Writes to it are ignored.
- R6: A write to word offset 0x0C is a doorbell. The destination peer is in bits [31:16] and the vector is in bits [7:0]; bits [15:8] are ignored. The request is accepted when three conditions hold: the destination is no greater than `max_peer`, the destination is below NUM_PEERS, and the vector is below that peer's count. Peer p's count is `peer_vec_cnt[p*CNT_W +: CNT_W]`.
- R7: An accepted doorbell raises `notify_valid` for exactly one cycle, in the cycle after the write. `notify_dest` and `notify_vector` hold the destination and vector of that request.
- R8: A rejected doorbell raises no `notify_valid`, and the mask and status words are left unchanged.
- R9: Registers are decoded from address bits [7:2]. Address bits [1:0] do not select anything.
- R10: Reads of word offsets 0x0C and 0x10 to 0xFC return zero. Writes to offsets 0x10 to 0xFC change nothing.
- R11: When `evt_valid` is 1, the status word is loaded with `evt_value` zero-extended. This takes priority over a bus write to the status word in the same cycle.
- R12: Read data is registered: `bus_rdata` shows the addressed word in the cycle after `bus_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Word write strobe |
| bus_rd_en | input | 1 | Word read strobe |
| bus_addr | input | 8 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| shm_mapped | input | 1 | Shared memory is mapped |
| own_id | input | 16 | Peer number assigned to this side |
| max_peer | input | 16 | Highest live peer number |
| peer_vec_cnt | input | NUM_PEERS*CNT_W | Vector count for each peer, with peer 0 in the low bits |
| evt_valid | input | 1 | Local event loads the status word |
| evt_value | input | EVT_W | Value loaded by the event |
| irq | output | 1 | Level interrupt |
| notify_valid | output | 1 | One-cycle notify pulse |
| notify_dest | output | 16 | Destination peer of the pulse |
| notify_vector | output | 8 | Vector of the pulse |

## Verification
The bench builds the block with NUM_PEERS=4, CNT_W=8 and EVT_W=8. The four peer counts are 2, 0, 3 and 1, so the table includes a peer that owns no vectors. Because the table is this small, the bench can sweep every destination from 0 to 5 against every vector from 0 to 4, under three `max_peer` settings. One of those settings lies above the table size, which exercises rejection by `max_peer`, rejection by table size and rejection by count. The bench also walks each of the 32 mask bits against a rotating status bit, and it writes to every undefined word offset in the window.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 6;   // word index = byte address [7:2]
  localparam int DEST_LSB = 16;  // doorbell destination field [31:16]
  localparam int DEST_W   = 16;
  localparam int VEC_W    = 8;   // doorbell vector field [7:0]

  localparam logic [IDX_W-1:0] IDX_MASK = 6'd0;
  localparam logic [IDX_W-1:0] IDX_STAT = 6'd1;
  localparam logic [IDX_W-1:0] IDX_POS  = 6'd2;
  localparam logic [IDX_W-1:0] IDX_BELL = 6'd3;

  typedef struct packed {
    logic mask;
    logic stat;
    logic pos;
    logic bell;
  } reg_sel_t;
endpackage

// File: rtl/dbell_addr_dec.sv
module dbell_addr_dec
  import dbell_pkg::*;
(
  input  logic [IDX_W-1:0] word_idx,
  output reg_sel_t         sel
);
  always_comb begin
    sel      = '0;
    sel.mask = (word_idx == IDX_MASK);
    sel.stat = (word_idx == IDX_STAT);
    sel.pos  = (word_idx == IDX_POS);
    sel.bell = (word_idx == IDX_BELL);
  end
endmodule

// File: rtl/dbell_irq_regs.sv
module dbell_irq_regs
  import dbell_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              stat_we,
  input  logic              stat_rd,
  input  logic [WORD_W-1:0] wdata,
  input  logic              evt_valid,
  input  logic [EVT_W-1:0]  evt_value,
  output logic [WORD_W-1:0] mask_q,
  output logic [WORD_W-1:0] stat_q,
  output logic              irq_q
);
  logic [WORD_W-1:0] stat_d;
  logic              stat_en;
  logic              irq_d;

  always_comb begin
    stat_en = evt_valid | stat_we | stat_rd;
    if (evt_valid)    stat_d = {{(WORD_W-EVT_W){1'b0}}, evt_value};
    else if (stat_we) stat_d = wdata;
    else              stat_d = '0;
    irq_d = |(stat_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      if (stat_en) stat_q <= stat_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/dbell_door_chk.sv
module dbell_door_chk
  import dbell_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bell_we,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [DEST_W-1:0]          max_peer,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt,
  output logic                       notify_valid,
  output logic [DEST_W-1:0]          notify_dest,
  output logic [VEC_W-1:0]           notify_vector
);
  localparam int CMP_W = (CNT_W > VEC_W) ? CNT_W : VEC_W;

  logic [CNT_W-1:0]  cnt_arr [NUM_PEERS];
  logic [DEST_W-1:0] dest;
  logic [VEC_W-1:0]  vec;
  logic [CNT_W-1:0]  sel_cnt;
  logic              in_table;
  logic              accept;

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_unpack
    assign cnt_arr[p] = peer_vec_cnt[p*CNT_W +: CNT_W];
  end

  always_comb begin
    dest     = wdata[DEST_LSB +: DEST_W];
    vec      = wdata[VEC_W-1:0];
    sel_cnt  = '0;
    in_table = 1'b0;
    for (int p = 0; p < NUM_PEERS; p++) begin
      if (dest == DEST_W'(p)) begin
        sel_cnt  = cnt_arr[p];
        in_table = 1'b1;
      end
    end
    accept = bell_we && in_table && (dest <= max_peer) &&
             (CMP_W'(vec) < CMP_W'(sel_cnt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_valid  <= 1'b0;
      notify_dest   <= '0;
      notify_vector <= '0;
    end else begin
      notify_valid <= accept;
      if (accept) begin
        notify_dest   <= dest;
        notify_vector <= vec;
      end
    end
  end
endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
  import dbell_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int CNT_W     = 8,
  parameter int EVT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [7:0]                 bus_addr,
  input  logic [WORD_W-1:0]          bus_wdata,
  output logic [WORD_W-1:0]          bus_rdata,
  input  logic                       shm_mapped,
  input  logic [DEST_W-1:0]          own_id,
  input  logic [DEST_W-1:0]          max_peer,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt,
  input  logic                       evt_valid,
  input  logic [EVT_W-1:0]           evt_value,
  output logic                       irq,
  output logic                       notify_valid,
  output logic [DEST_W-1:0]          notify_dest,
  output logic [VEC_W-1:0]           notify_vector
);
  reg_sel_t          sel;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] rdata_d;

  dbell_addr_dec u_dec (
    .word_idx (bus_addr[7:2]),
    .sel      (sel)
  );

  dbell_irq_regs #(.EVT_W(EVT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (bus_wr_en & sel.mask),
    .stat_we   (bus_wr_en & sel.stat),
    .stat_rd   (bus_rd_en & sel.stat),
    .wdata     (bus_wdata),
    .evt_valid (evt_valid),
    .evt_value (evt_value),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .irq_q     (irq)
  );

  dbell_door_chk #(.NUM_PEERS(NUM_PEERS), .CNT_W(CNT_W)) u_bell (
    .clk           (clk),
    .rst_n         (rst_n),
    .bell_we       (bus_wr_en & sel.bell),
    .wdata         (bus_wdata),
    .max_peer      (max_peer),
    .peer_vec_cnt  (peer_vec_cnt),
    .notify_valid  (notify_valid),
    .notify_dest   (notify_dest),
    .notify_vector (notify_vector)
  );

  always_comb begin
    rdata_d = '0;
    if (sel.mask) rdata_d = mask_q;
    if (sel.stat) rdata_d = stat_q;
    if (sel.pos)  rdata_d = shm_mapped ? {{(WORD_W-DEST_W){1'b0}}, own_id} : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/dbell_regblk_chk.sv
module dbell_regblk_chk #(
  parameter int EVT_W = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [15:0] max_peer,
  input logic        evt_valid,
  input logic [EVT_W-1:0] evt_value,
  input logic [31:0] mask_q,
  input logic [31:0] stat_q,
  input logic        irq,
  input logic        notify_valid
);
  // R7
  notify_from_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> ($past(bus_wr_en) && ($past(bus_addr[7:2]) == 6'd3)));

  // R6
  notify_dest_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> ($past(bus_wdata[31:16]) <= $past(max_peer)));

  // R3
  stat_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr[7:2] == 6'd1 && !bus_wr_en && !evt_valid) |=> (stat_q == 32'd0));

  // R11
  evt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (stat_q == {{(32-EVT_W){1'b0}}, $past(evt_value)}));

  // R4
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q == 32'd0) && $past(mask_q == 32'd0)) |-> !irq);

  // R10
  undef_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[7:2] > 6'd3 && !bus_rd_en && !evt_valid) |=>
      ($stable(mask_q) && $stable(stat_q)));
endmodule

bind dbell_regblk dbell_regblk_chk #(.EVT_W(EVT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr_en    (bus_wr_en),
  .bus_rd_en    (bus_rd_en),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .max_peer     (max_peer),
  .evt_valid    (evt_valid),
  .evt_value    (evt_value),
  .mask_q       (mask_q),
  .stat_q       (stat_q),
  .irq          (irq),
  .notify_valid (notify_valid)
);

// File: tb/tb_dbell_regblk.sv
module tb_dbell_regblk;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int CW  = 8;
  localparam int EW  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        shm_mapped;
  logic [15:0] own_id, max_peer;
  logic [NP*CW-1:0] peer_vec_cnt;
  logic        evt_valid;
  logic [EW-1:0] evt_value;
  logic        irq, notify_valid;
  logic [15:0] notify_dest;
  logic [7:0]  notify_vector;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  dbell_regblk #(.NUM_PEERS(NP), .CNT_W(CW), .EVT_W(EW)) dut (
    .clk, .rst_n, .bus_wr_en, .bus_rd_en, .bus_addr, .bus_wdata, .bus_rdata,
    .shm_mapped, .own_id, .max_peer, .peer_vec_cnt, .evt_valid, .evt_value,
    .irq, .notify_valid, .notify_dest, .notify_vector
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int cnt_of(input int p);
    case (p)
      0: return 2;
      1: return 0;
      2: return 3;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr_en = 0; bus_rd_en = 0; bus_addr = 0; bus_wdata = 0;
    shm_mapped = 0; own_id = 16'd3; max_peer = 16'd3; evt_valid = 0; evt_value = 0;
    peer_vec_cnt = {8'd1, 8'd3, 8'd0, 8'd2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);
    chk(notify_valid == 1'b0, "R1 notify", {31'd0, notify_valid}, 0);
    rd(8'h00, v); chk(v == 0, "R1 mask", v, 0);
    rd(8'h04, v); chk(v == 0, "R1 status", v, 0);

    // R2 mask readback, R9 low address bits, R12 registered read
    wr(8'h00, 32'hA5A5_0F0F);
    rd(8'h00, v); chk(v == 32'hA5A5_0F0F, "R2 R12 mask rd", v, 32'hA5A5_0F0F);
    rd(8'h03, v); chk(v == 32'hA5A5_0F0F, "R9 addr[1:0]", v, 32'hA5A5_0F0F);
    wr(8'h02, 32'h0000_1234);
    rd(8'h00, v); chk(v == 32'h0000_1234, "R9 wr addr[1:0]", v, 32'h1234);

    // R3 / R4 status write, irq lag, read clear
    wr(8'h04, 32'h0000_0200);
    chk(irq == 1'b0, "R4 lag", {31'd0, irq}, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R4 rise", {31'd0, irq}, 1);
    rd(8'h04, v); chk(v == 32'h200, "R3 read value", v, 32'h200);
    rd(8'h04, v); chk(v == 0, "R3 cleared", v, 0);
    chk(irq == 1'b0, "R4 fall", {31'd0, irq}, 0);

    // R4 sweep of mask bits against rotating status bit
    for (int i = 0; i < 32; i++) begin
      int sb;
      sb = (i * 7) % 32;
      wr(8'h00, 32'd1 << i);
      wr(8'h04, 32'd1 << sb);
      @(negedge clk);
      chk(irq == (i == sb), "R4 sweep", {31'd0, irq}, {31'd0, (i == sb)});
    end

    // R5 own position
    rd(8'h08, v); chk(v == 32'hFFFF_FFFF, "R5 unmapped", v, 32'hFFFF_FFFF);
    shm_mapped = 1'b1;
    rd(8'h08, v); chk(v == 32'd3, "R5 mapped", v, 3);
    wr(8'h08, 32'h0000_0055);
    rd(8'h08, v); chk(v == 32'd3, "R5 write ignored", v, 3);

    // R10 undefined offsets
    wr(8'h00, 32'h0000_F00D);
    wr(8'h04, 32'h0000_0055);
    for (int a = 16; a < 256; a += 4) wr(8'(a), 32'hFFFF_FFFF);
    for (int a = 16; a < 256; a += 4) begin
      rd(8'(a), v);
      chk(v == 0, "R10 undef read", v, 0);
    end
    rd(8'h0C, v); chk(v == 0, "R10 bell read", v, 0);
    rd(8'h00, v); chk(v == 32'hF00D, "R10 mask kept", v, 32'hF00D);
    rd(8'h04, v); chk(v == 32'h55, "R10 status kept", v, 32'h55);

    // R11 event load and priority
    evt_valid = 1'b1; evt_value = 8'h3C;
    @(negedge clk);
    evt_valid = 1'b0;
    rd(8'h04, v); chk(v == 32'h3C, "R11 event load", v, 32'h3C);
    evt_valid = 1'b1; evt_value = 8'hC3;
    wr(8'h04, 32'h1234_5678);
    evt_valid = 1'b0;
    rd(8'h04, v); chk(v == 32'hC3, "R11 event priority", v, 32'hC3);

    // R6 R7 R8 doorbell sweep
    wr(8'h00, 32'h0000_00FF);
    wr(8'h04, 32'h0000_0011);
    for (int m = 0; m < 3; m++) begin
      int mp;
      mp = (m == 0) ? 1 : ((m == 1) ? 3 : 5);
      max_peer = 16'(mp);
      for (int d = 0; d < 6; d++) begin
        for (int k = 0; k < 5; k++) begin
          bit ok;
          ok = (d <= mp) && (d < NP) && (k < cnt_of(d));
          wr(8'h0C, {16'(d), 8'hEE, 8'(k)});
          chk(notify_valid == ok, ok ? "R6 accept" : "R8 reject",
              {31'd0, notify_valid}, {31'd0, ok});
          if (ok) begin
            chk(notify_dest == 16'(d), "R7 dest", {16'd0, notify_dest}, d);
            chk(notify_vector == 8'(k), "R7 vector", {24'd0, notify_vector}, k);
          end
          @(negedge clk);
          chk(notify_valid == 1'b0, "R7 single pulse", {31'd0, notify_valid}, 0);
        end
      end
    end
    rd(8'h00, v); chk(v == 32'hFF, "R8 mask untouched", v, 32'hFF);
    rd(8'h04, v); chk(v == 32'h11, "R8 status untouched", v, 32'h11);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule